// File: doc/BRIEF.md
# I2C Arbitration and Bus-Condition Monitor

This block watches the I2C clock and data pad inputs together with what this device is currently trying to put on the bus. It reports three sticky flags and one level. The first flag says that this device lost arbitration. The other two say that a start condition or a stop condition was seen. The level says whether the bus is busy. Software clears each flag with its own write-one strobe. Driving the pads and the register interface belong to other blocks.

Both pad inputs first pass through a synchronizer. After that, a glitch filter accepts a new level only once it has been stable for a set number of samples. Bus conditions and clock edges are decoded from these filtered values.

Arbitration loss is caught in four situations:
- a bit mismatch when SCL rises;
- a foreign repeated start that lands on a transmitted 1;
- a repeated start that this master could not complete;
- a stop that this master could not complete.

Start and stop reporting is suppressed while the device is an idle slave.

The intended action `act` uses this encoding:

| `act` | Meaning |
|---|---|
| 0 | send 0 |
| 1 | send 1 |
| 2 | repeated start |
| 3 | stop |

Top module: `i2c_arb_monitor`

## Requirements
- R1: While reset is asserted, and right after it is released, `arb_lost`, `start_seen`, `stop_seen` and `bus_busy` are 0.
- R2: A start is filtered SDA falling while filtered SCL is high, and a stop is filtered SDA rising while filtered SCL is high. A pad change reaches the outputs at the SYNC_STAGES+FILT_LEN+2th rising clock edge after it occurs. That is 7 edges with the defaults. `bus_busy` is set by a start and cleared by a stop.
- R3: A pad level that lasts fewer than FILT_LEN clock cycles is ignored and produces no bus condition.
- R4: `start_seen` and `stop_seen` are set by their bus conditions only while `is_master` is 1 or `idle_slave` is 0. The one exception is R7.
- R5: `arb_lost` never sets while `xmit_active` is 0.
- R6: With `xmit_active` set and `act` equal to 1 or 2, a filtered SCL rising edge that finds filtered SDA at 0 sets `arb_lost`.
- R7: With `xmit_active` set and `act` equal to 1, a start condition sets `arb_lost`. It also sets `start_seen`, even for an idle slave.
- R8: With `xmit_active` and `is_master` set and `act` equal to 2, a filtered SCL falling edge while SDA is still high sets `arb_lost`.
- R9: With `xmit_active` and `is_master` set and `act` equal to 3, a filtered SCL falling edge while SDA is still low sets `arb_lost`.
- R10: `clr_arl`, `clr_start` and `clr_stop` each clear their own flag at the next clock edge. If a set event for the same flag falls on that edge, the flag stays 1.
- R11: A `bus_timeout` pulse clears `bus_busy` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL pad input |
| sda_in | input | 1 | SDA pad input |
| xmit_active | input | 1 | Device is transmitting on SDA |
| is_master | input | 1 | Device is the bus master |
| act | input | 2 | Intended action: 0 send 0, 1 send 1, 2 repeated start, 3 stop |
| idle_slave | input | 1 | Slave is ignoring the bus until the next start |
| clr_arl | input | 1 | Write-one clear of `arb_lost` |
| clr_start | input | 1 | Write-one clear of `start_seen` |
| clr_stop | input | 1 | Write-one clear of `stop_seen` |
| bus_timeout | input | 1 | Bus timeout pulse |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| start_seen | output | 1 | Sticky start-seen flag |
| stop_seen | output | 1 | Sticky stop-seen flag |
| bus_busy | output | 1 | Bus is busy |

## Verification
A pad change reaches every output at the seventh rising edge after it occurs. The latency checks therefore drive the pad on a falling edge and read the outputs 1 ns after the sixth rising edge, where nothing may have changed yet, and again after the seventh, where the change must show. The glitch check uses a pulse one cycle shorter than the filter. The same-edge check places the clear strobe on exactly that seventh edge.

Strobe inputs (`clr_*`, `bus_timeout`) act at the very next edge and are checked 1 ns after it. The collision sweeps hold each pad level for ten cycles, well past the latency, before they compare the flags with values computed from the requirement conditions.

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       xmit_active,
  input  logic       is_master,
  input  logic [1:0] act,
  input  logic       idle_slave,
  input  logic       clr_arl,
  input  logic       clr_start,
  input  logic       clr_stop,
  input  logic       bus_timeout,
  output logic       arb_lost,
  output logic       start_seen,
  output logic       stop_seen,
  output logic       bus_busy
);
  localparam logic [1:0] ACT_ONE = 2'd1, ACT_RSTART = 2'd2, ACT_STOP = 2'd3;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic [FILT_LEN-1:0]    scl_hist, sda_hist;
  logic scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_hist <= '1;
      sda_hist <= '1;
      scl_f    <= 1'b1;
      sda_f    <= 1'b1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_hist <= {scl_hist[FILT_LEN-2:0], scl_sync[SYNC_STAGES-1]};
      sda_hist <= {sda_hist[FILT_LEN-2:0], sda_sync[SYNC_STAGES-1]};
      if (&scl_hist)       scl_f <= 1'b1;
      else if (~|scl_hist) scl_f <= 1'b0;
      if (&sda_hist)       sda_f <= 1'b1;
      else if (~|sda_hist) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_cond, stop_cond;
  assign scl_rise   = scl_f & ~scl_p;
  assign scl_fall   = ~scl_f & scl_p;
  assign start_cond = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_cond  = scl_f & scl_p & ~sda_p & sda_f;

  logic lose_bit, lose_fstart, lose_rstart, lose_stop, arl_set;
  assign lose_bit    = (act == ACT_ONE || act == ACT_RSTART) & scl_rise & ~sda_f;
  assign lose_fstart = (act == ACT_ONE) & start_cond;
  assign lose_rstart = is_master & (act == ACT_RSTART) & scl_fall & sda_p;
  assign lose_stop   = is_master & (act == ACT_STOP) & scl_fall & ~sda_p;
  assign arl_set     = xmit_active & (lose_bit | lose_fstart | lose_rstart | lose_stop);

  logic engaged, start_set, stop_set;
  assign engaged   = is_master | ~idle_slave;
  assign start_set = start_cond & (engaged | (xmit_active & lose_fstart));
  assign stop_set  = stop_cond & engaged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost   <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      bus_busy   <= 1'b0;
    end else begin
      arb_lost   <= arl_set | (arb_lost & ~clr_arl);
      start_seen <= start_set | (start_seen & ~clr_start);
      stop_seen  <= stop_set | (stop_seen & ~clr_stop);
      bus_busy   <= start_cond | (bus_busy & ~stop_cond & ~bus_timeout);
    end
  end

  // R5
  arb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(xmit_active));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_seen) |-> bus_busy);

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> !bus_busy);

  // R4
  stop_engaged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> $past(is_master || !idle_slave));

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> $past(bus_timeout || stop_cond));

  // R10
  arl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_arl && !arl_set) |=> !arb_lost);
endmodule

// File: tb/i2c_arb_monitor_test.sv
module i2c_arb_monitor_test;
  localparam int S = 2, F = 3, LAT = S + F + 2, HOLD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic xa = 1'b0, ms = 1'b0, idl = 1'b0;
  logic [1:0] act = 2'd0;
  logic c_arl = 1'b0, c_st = 1'b0, c_sp = 1'b0, tmo = 1'b0;
  logic arl, sts, sps, busy;
  int checks = 0, errs = 0, cyc = 0;

  always #10 clk = ~clk;

  i2c_arb_monitor #(.SYNC_STAGES(S), .FILT_LEN(F)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .xmit_active(xa), .is_master(ms), .act(act), .idle_slave(idl),
    .clr_arl(c_arl), .clr_start(c_st), .clr_stop(c_sp), .bus_timeout(tmo),
    .arb_lost(arl), .start_seen(sts), .stop_seen(sps), .bus_busy(busy));

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic pads(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (HOLD) @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk);
    c_arl = 1'b1; c_st = 1'b1; c_sp = 1'b1;
    @(negedge clk);
    c_arl = 1'b0; c_st = 1'b0; c_sp = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 arb in reset", arl, 1'b0);
    chk("R1 busy in reset", busy, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (HOLD) @(posedge clk);
    #1;
    chk("R1 arb after reset", arl, 1'b0);
    chk("R1 start after reset", sts, 1'b0);
    chk("R1 stop after reset", sps, 1'b0);
    chk("R1 busy after reset", busy, 1'b0);

    // R2 exact latency of a start, non-idle slave
    @(negedge clk) sda = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    #1;
    chk("R2 busy before latency", busy, 1'b0);
    chk("R2 start before latency", sts, 1'b0);
    @(posedge clk);
    #1;
    chk("R2 busy at latency", busy, 1'b1);
    chk("R2 start at latency", sts, 1'b1);
    clear_all();
    #1 chk("R10 clr_start clears", sts, 1'b0);
    pads(1'b1, 1'b1);
    chk("R2 stop sets flag", sps, 1'b1);
    chk("R2 stop clears busy", busy, 1'b0);
    clear_all();
    #1 chk("R10 clr_stop clears", sps, 1'b0);

    // R4 idle slave suppresses start and stop
    idl = 1'b1;
    pads(1'b1, 1'b0);
    chk("R4 idle start suppressed", sts, 1'b0);
    chk("R2 busy set by start", busy, 1'b1);
    pads(1'b1, 1'b1);
    chk("R4 idle stop suppressed", sps, 1'b0);
    chk("R2 busy cleared by stop", busy, 1'b0);
    ms = 1'b1;
    pads(1'b1, 1'b0);
    chk("R4 master start reported", sts, 1'b1);
    pads(1'b1, 1'b1);
    chk("R4 master stop reported", sps, 1'b1);
    ms = 1'b0;
    clear_all();

    // R3 glitch shorter than the filter is ignored
    @(negedge clk) sda = 1'b0;
    repeat (F - 1) @(negedge clk);
    sda = 1'b1;
    repeat (HOLD) @(posedge clk);
    #1;
    chk("R3 glitch no busy", busy, 1'b0);
    chk("R3 glitch no start", sts, 1'b0);
    idl = 1'b0;

    // R6 / R5 sweep: SDA low at SCL rise, slave
    for (int x = 0; x < 2; x++) begin
      for (int a = 0; a < 4; a++) begin
        pads(1'b0, 1'b0);
        xa = x[0];
        act = a[1:0];
        pads(1'b1, 1'b0);
        chk($sformatf("R6 R5 bit loss x=%0d a=%0d", x, a), arl,
            x == 1 && (a == 1 || a == 2));
        pads(1'b0, 1'b0);
        xa = 1'b0;
        clear_all();
      end
    end

    // R7 sweep: foreign repeated start, idle slave
    idl = 1'b1;
    for (int x = 0; x < 2; x++) begin
      for (int a = 0; a < 4; a++) begin
        pads(1'b0, 1'b1);
        xa = x[0];
        act = a[1:0];
        pads(1'b1, 1'b1);
        pads(1'b1, 1'b0);
        chk($sformatf("R7 fstart arb x=%0d a=%0d", x, a), arl, x == 1 && a == 1);
        chk($sformatf("R7 fstart flag x=%0d a=%0d", x, a), sts, x == 1 && a == 1);
        pads(1'b0, 1'b0);
        xa = 1'b0;
        clear_all();
      end
    end
    idl = 1'b0;

    // R8 / R9 sweep over master
    for (int m = 0; m < 2; m++) begin
      pads(1'b0, 1'b1);
      xa = 1'b1;
      ms = m[0];
      act = 2'd2;
      pads(1'b1, 1'b1);
      pads(1'b0, 1'b1);
      chk($sformatf("R8 rstart loss m=%0d", m), arl, m == 1);
      xa = 1'b0;
      clear_all();
      pads(1'b0, 1'b0);
      xa = 1'b1;
      act = 2'd3;
      pads(1'b1, 1'b0);
      pads(1'b0, 1'b0);
      chk($sformatf("R9 stop loss m=%0d", m), arl, m == 1);
      xa = 1'b0;
      ms = 1'b0;
      clear_all();
    end
    act = 2'd0;
    #1 chk("R10 clr_arl clears", arl, 1'b0);

    // R10 set wins over a clear on the same edge
    pads(1'b0, 1'b1);
    pads(1'b1, 1'b1);
    pads(1'b1, 1'b0);
    chk("R10 start flag preset", sts, 1'b1);
    pads(1'b1, 1'b1);
    @(negedge clk) sda = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    #1 c_st = 1'b1;
    @(posedge clk);
    #1 c_st = 1'b0;
    chk("R10 set wins over clear", sts, 1'b1);

    // R11 timeout clears busy
    chk("R11 busy before timeout", busy, 1'b1);
    @(negedge clk) tmo = 1'b1;
    @(posedge clk);
    #1 tmo = 1'b0;
    chk("R11 timeout clears busy", busy, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule